// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's byte-wide load/store port and a slower memory that moves whole blocks. It keeps one entry per index. Each entry holds a valid flag, a dirty flag, a tag and one block of bytes. The cache answers a load or store from its own storage when the addressed block is present.

When the block is absent, the cache first copies a modified victim block back to memory. It then reads the wanted block in and finishes the original access. Stores are kept in the cache and reach memory only when their block is later replaced. A store that misses brings its block in first and then merges the byte into it.

The processor must hold its request steady until it sees ready. The memory must answer every request with an acknowledge. One-cycle flags report each hit, each miss and each replacement of a valid entry.

Top module: `dm_wb_cache`

## Requirements
- R1: The address is split, from most to least significant, into a tag of ADDR_W-INDEX_W-OFFSET_W bits, an index of INDEX_W bits and an offset of OFFSET_W bits. With the defaults (4-bit address, 2-bit index, 1-bit offset) the tag is address bit 3, the index is bits 2:1 and the offset is bit 0. The memory port carries the block address, which is the address without its offset bits. Byte k of a block occupies bits 8k+7:8k of the block bus.
- R2: An access hits only when the indexed entry is valid and its stored tag equals the address tag. On a hit, hit_pulse and cpu_ready are high in the first cycle of the request, and a load's byte is on cpu_rdata in that same cycle.
- R3: After reset every entry is invalid. The first access to any index is therefore a miss without an eviction, and reset leaves cpu_ready, mem_req and all flags low.
- R4: On a miss, miss_pulse is high for the first cycle of the request and cpu_ready stays low until the block has been read from memory. The access then completes, with cpu_ready high for one cycle. A block that has just been filled is clean.
- R5: A store that hits updates the cached byte, marks the entry dirty and issues no memory write.
- R6: evict_pulse accompanies a miss whose indexed entry is valid. If that entry is dirty, its block is written to its own block address before the new block is read. If it is clean, nothing is written.
- R7: A store miss allocates. The block is read from memory, the store byte is merged into it, and the other bytes keep their memory values.
- R8: The offset field selects which byte of the block a load returns.
- R9: Once mem_req is raised, it stays high with a stable mem_we and mem_addr until the cycle in which mem_ack is high.
- R10: With the default configuration, the sequence load 1100, store 1101, load 0100, load 1100 gives:
  - a miss;
  - a hit;
  - a miss with eviction and one write-back;
  - a miss with eviction and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every valid flag |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 8 | Load byte, valid while cpu_ready is high |
| mem_req | output | 1 | Memory block transfer request |
| mem_we | output | 1 | 1 for a write-back, 0 for a block read |
| mem_addr | output | ADDR_W-OFFSET_W | Block address |
| mem_wdata | output | 8<<OFFSET_W | Block written back |
| mem_ack | input | 1 | Memory finishes the current transfer |
| mem_rdata | input | 8<<OFFSET_W | Block read from memory, sampled with mem_ack |
| hit_pulse | output | 1 | One-cycle hit flag |
| miss_pulse | output | 1 | One-cycle miss flag |
| evict_pulse | output | 1 | One-cycle flag when a valid entry is replaced |

## Verification
The bench separates dirty evictions from clean ones. A design that ignored the dirty flag would either lose stored bytes or write clean blocks back. Lost bytes show up as wrong data when an evicted line is read again, and extra writes show up in the count of memory writes.

A store miss is followed by a load of the neighbouring byte and then of the stored byte. This catches a merge that clobbers the filled block, and also a store that completes without allocating.

Loads that follow a write-back return the written-back byte, which exposes a write-back sent to the wrong block address. A reset taken in the middle of a run must make the first access miss without an eviction, which catches valid flags that survive reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               dirty_set,
    output logic               ent_valid,
    output logic               ent_dirty,
    output logic [TAG_W-1:0]   ent_tag
);
    localparam int ENTRIES = 1 << INDEX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
    } tags_t;

    tags_t tags_d, tags_q;

    always_comb begin
        tags_d = tags_q;
        if (fill_en) begin
            tags_d.valid[idx] = 1'b1;
            tags_d.dirty[idx] = 1'b0;
            tags_d.tag[idx]   = fill_tag;
        end
        if (dirty_set) begin
            tags_d.dirty[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags_q <= '0;
        end else begin
            tags_q <= tags_d;
        end
    end

    assign ent_valid = tags_q.valid[idx];
    assign ent_dirty = tags_q.dirty[idx];
    assign ent_tag   = tags_q.tag[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W  = 2,
    parameter int OFFSET_W = 1
) (
    input  logic                          clk,
    input  logic [INDEX_W-1:0]            idx,
    input  logic [OFFSET_W-1:0]           off,
    input  logic                          fill_en,
    input  logic [(BYTE_W<<OFFSET_W)-1:0] fill_blk,
    input  logic                          byte_we,
    input  logic [BYTE_W-1:0]             wbyte,
    output logic [(BYTE_W<<OFFSET_W)-1:0] blk,
    output logic [BYTE_W-1:0]             rbyte
);
    localparam int ENTRIES   = 1 << INDEX_W;
    localparam int BLK_BYTES = 1 << OFFSET_W;
    localparam int BLK_W     = BYTE_W * BLK_BYTES;

    logic [ENTRIES-1:0][BLK_W-1:0] mem_d, mem_q;
    logic [BLK_BYTES-1:0][BYTE_W-1:0] lanes;

    always_comb begin
        mem_d = mem_q;
        if (fill_en) begin
            mem_d[idx] = fill_blk;
        end
        if (byte_we) begin
            mem_d[idx][int'(off)*BYTE_W +: BYTE_W] = wbyte;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign blk = mem_q[idx];

    for (genvar k = 0; k < BLK_BYTES; k++) begin : g_lane
        assign lanes[k] = blk[k*BYTE_W +: BYTE_W];
    end

    assign rbyte = lanes[off];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic ent_valid,
    input  logic ent_dirty,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic hit_pulse,
    output logic miss_pulse,
    output logic evict_pulse,
    output logic mem_req,
    output logic mem_we,
    output logic use_old_tag,
    output logic fill_en,
    output logic store_en
);
    typedef struct packed {
        dmc_state_e state;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        cpu_ready   = 1'b0;
        hit_pulse   = 1'b0;
        miss_pulse  = 1'b0;
        evict_pulse = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        use_old_tag = 1'b0;
        fill_en     = 1'b0;
        store_en    = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        hit_pulse = 1'b1;
                        cpu_ready = 1'b1;
                        store_en  = cpu_we;
                    end else begin
                        miss_pulse   = 1'b1;
                        evict_pulse  = ent_valid;
                        ctrl_d.state = (ent_valid && ent_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                use_old_tag = 1'b1;
                if (mem_ack) begin
                    ctrl_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en      = 1'b1;
                    ctrl_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready    = 1'b1;
                store_en     = cpu_we;
                ctrl_d.state = ST_IDLE;
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int INDEX_W  = 2,
    parameter int OFFSET_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [BYTE_W-1:0]             cpu_wdata,
    output logic                          cpu_ready,
    output logic [BYTE_W-1:0]             cpu_rdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-OFFSET_W-1:0]    mem_addr,
    output logic [(BYTE_W<<OFFSET_W)-1:0] mem_wdata,
    input  logic                          mem_ack,
    input  logic [(BYTE_W<<OFFSET_W)-1:0] mem_rdata,
    output logic                          hit_pulse,
    output logic                          miss_pulse,
    output logic                          evict_pulse
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
    localparam int BLK_W = BYTE_W << OFFSET_W;

    logic [TAG_W-1:0]    a_tag;
    logic [INDEX_W-1:0]  a_idx;
    logic [OFFSET_W-1:0] a_off;

    logic             ent_valid, ent_dirty;
    logic [TAG_W-1:0] ent_tag;
    logic             hit, use_old_tag, fill_en, store_en;
    logic [BLK_W-1:0] blk;

    assign {a_tag, a_idx, a_off} = cpu_addr;
    assign hit = ent_valid && (ent_tag == a_tag);

    dmc_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (a_idx),
        .fill_en   (fill_en),
        .fill_tag  (a_tag),
        .dirty_set (store_en),
        .ent_valid (ent_valid),
        .ent_dirty (ent_dirty),
        .ent_tag   (ent_tag)
    );

    dmc_data_store #(
        .INDEX_W  (INDEX_W),
        .OFFSET_W (OFFSET_W)
    ) u_data (
        .clk      (clk),
        .idx      (a_idx),
        .off      (a_off),
        .fill_en  (fill_en),
        .fill_blk (mem_rdata),
        .byte_we  (store_en),
        .wbyte    (cpu_wdata),
        .blk      (blk),
        .rbyte    (cpu_rdata)
    );

    dmc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .hit         (hit),
        .ent_valid   (ent_valid),
        .ent_dirty   (ent_dirty),
        .mem_ack     (mem_ack),
        .cpu_ready   (cpu_ready),
        .hit_pulse   (hit_pulse),
        .miss_pulse  (miss_pulse),
        .evict_pulse (evict_pulse),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .use_old_tag (use_old_tag),
        .fill_en     (fill_en),
        .store_en    (store_en)
    );

    assign mem_addr  = use_old_tag ? {ent_tag, a_idx} : {a_tag, a_idx};
    assign mem_wdata = blk;

endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
    parameter int BA_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ready,
    input logic            hit_pulse,
    input logic            miss_pulse,
    input logic            evict_pulse,
    input logic            mem_req,
    input logic            mem_we,
    input logic [BA_W-1:0] mem_addr,
    input logic            mem_ack
);
    // R2
    hit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> cpu_ready && !miss_pulse);

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> !cpu_ready);

    // R4
    miss_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> !cpu_ready && mem_req);

    // R6
    evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_pulse |-> miss_pulse);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

    // R4
    ack_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);

endmodule

bind dm_wb_cache dm_wb_cache_chk #(.BA_W(ADDR_W - OFFSET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ready   (cpu_ready),
    .hit_pulse   (hit_pulse),
    .miss_pulse  (miss_pulse),
    .evict_pulse (evict_pulse),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/dm_wb_cache_tb.sv
`timescale 1ns/1ps
module dm_wb_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [2:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata;
    logic        hit_pulse, miss_pulse, evict_pulse;

    always #2.5 clk = ~clk;

    dm_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
        .evict_pulse(evict_pulse)
    );

    // memory model: 8 blocks of 2 bytes
    logic [15:0] mem [8];
    int lat_cnt = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int lat = 2;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    int errors = 0;
    int checks = 0;
    logic [7:0] ref_mem [16];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [3:0] a, input logic [7:0] wd,
                          output logic h, output logic m, output logic e,
                          output int waits, output logic [7:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        h = hit_pulse; m = miss_pulse; e = evict_pulse; waits = 0;
        while (!cpu_ready && waits < 100) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic       we;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic       hit;
        logic       evict;
        logic       wb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'hC, 8'h00, 1'b0, 1'b0, 1'b0},  // R10 load 1100 miss
        '{1'b1, 4'hD, 8'h5A, 1'b1, 1'b0, 1'b0},  // R10 R5 store 1101 hit
        '{1'b0, 4'h4, 8'h00, 1'b0, 1'b1, 1'b1},  // R10 R6 dirty eviction
        '{1'b0, 4'hC, 8'h00, 1'b0, 1'b1, 1'b0},  // R10 R6 clean eviction
        '{1'b0, 4'hD, 8'h00, 1'b1, 1'b0, 1'b0},  // R8 written-back byte
        '{1'b1, 4'h2, 8'h77, 1'b0, 1'b0, 1'b0},  // R7 store miss
        '{1'b0, 4'h3, 8'h00, 1'b1, 1'b0, 1'b0},  // R7 neighbour kept
        '{1'b0, 4'h2, 8'h00, 1'b1, 1'b0, 1'b0},  // R7 merged byte
        '{1'b0, 4'hA, 8'h00, 1'b0, 1'b1, 1'b1},  // R6 allocated block dirty
        '{1'b0, 4'h2, 8'h00, 1'b0, 1'b1, 1'b0},  // R6 reload
        '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 cold
        '{1'b0, 4'hE, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 cold
        '{1'b1, 4'hF, 8'h11, 1'b1, 1'b0, 1'b0},  // R5 store hit
        '{1'b0, 4'h7, 8'h00, 1'b0, 1'b1, 1'b1},  // R6 dirty
        '{1'b0, 4'hF, 8'h00, 1'b0, 1'b1, 1'b0}   // R8 R1 reload
    };

    logic done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic h, m, e;
        logic [7:0] rd;
        int waits, wr0, rd0;
        for (int b = 0; b < 8; b++) begin
            mem[b] = {8'(8'h31 + 2*b), 8'(8'h30 + 2*b)};
        end
        for (int a = 0; a < 16; a++) ref_mem[a] = 8'(8'h30 + a);

        repeat (3) @(posedge clk);
        #1;
        // R3 reset state
        check("R3 ready in reset", int'(cpu_ready), 0);
        check("R3 mem_req in reset", int'(mem_req), 0);
        check("R3 flags in reset", int'({hit_pulse, miss_pulse, evict_pulse}), 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lat = (i % 3) + 1;
            wr0 = wr_cnt; rd0 = rd_cnt;
            access(VEC[i].we, VEC[i].addr, VEC[i].wdata, h, m, e, waits, rd);
            check($sformatf("R2 hit flag step %0d", i), int'(h), int'(VEC[i].hit));
            check($sformatf("R4 miss flag step %0d", i), int'(m), int'(!VEC[i].hit));
            check($sformatf("R6 evict flag step %0d", i), int'(e), int'(VEC[i].evict));
            check($sformatf("R6 R5 writes step %0d", i), wr_cnt - wr0, int'(VEC[i].wb));
            check($sformatf("R4 reads step %0d", i), rd_cnt - rd0, VEC[i].hit ? 0 : 1);
            if (VEC[i].hit) begin
                check($sformatf("R2 no stall step %0d", i), waits, 0);
            end else begin
                check($sformatf("R4 stall step %0d", i), int'(waits >= 2), 1);
            end
            if (VEC[i].we) begin
                ref_mem[VEC[i].addr] = VEC[i].wdata;
            end else begin
                check($sformatf("R8 load data step %0d", i), int'(rd), int'(ref_mem[VEC[i].addr]));
            end
        end

        // R3 reset mid-run: all entries clean, so memory holds every byte
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr0 = wr_cnt;
        access(1'b0, 4'hF, 8'h00, h, m, e, waits, rd);
        check("R3 miss after reset", int'(m), 1);
        check("R3 no evict after reset", int'(e), 0);
        check("R3 no write after reset", wr_cnt - wr0, 0);
        check("R3 data after reset", int'(rd), int'(ref_mem[4'hF]));

        // R1 block address and byte lanes: other index, tag 1, offset 1
        access(1'b0, 4'hB, 8'h00, h, m, e, waits, rd);
        check("R1 lane1 of block 5", int'(rd), int'(mem[5][15:8]));
        check("R1 miss cold index", int'(m), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule